// File: doc/BRIEF.md
# UART interrupt identification and gating

This block is the interrupt section of a 16550-class serial port. It holds a four-bit enable register and tracks four interrupt causes:
- line status
- received data
- transmit holding register empty
- modem status

It folds the active causes into a three-bit identification value for the host. It also drives an interrupt request level toward the system interrupt controller.

The received-data, line-status and modem-status causes each remember an event that arrives while the cause is disabled. The remembered event turns into a live interrupt as soon as the host enables that cause. The transmit cause has no such memory. When its enable turns on while the holding register is already empty, the interrupt comes up at once. It goes away when the host writes the holding register, reads the identification value, or disables the cause.

The general-purpose output bit of the modem control register (here the `out2` input) gates only the request pin. The identification value never depends on it. All outputs come from registers or from logic fed only by registers, so no input reaches an output in the same cycle.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After a synchronous reset, `ier_q` reads 0, `iir_q` reads 3'b001 and `irq` is 0.
- R2: A write with `ier_wr` loads `ier_wdata` into `ier_q`, which shows the new value after that clock edge. The bits are: bit 0 enables received data, bit 1 enables transmit empty, bit 2 enables line status, bit 3 enables modem status.
- R3: A received-data, line-status or modem-status event that arrives while its enable is 0 does not show in `iir_q`. A later change of that enable from 0 to 1 makes it active. An event that arrives while the enable is 1 is active at once.
- R4: Clearing the enable of a received-data, line-status or modem-status cause that is active hides it again, and re-enabling brings it back. Its acknowledge strobe (`rx_ack`, `ls_ack`, `ms_ack`) discards it whether it is hidden or active.
- R5: Changing the transmit enable from 0 to 1 while `thr_empty` is 1 makes the transmit interrupt active. When `thr_empty` is 0 at that moment, nothing happens.
- R6: The transmit interrupt is cleared by clearing its enable, by a `thr_wr` strobe, and by an `iir_rd` strobe.
- R7: A `thr_load` pulse (byte moved to the shifter) raises the transmit interrupt if its enable is 1. When its enable is 0, the pulse is not remembered.
- R8: An `ovr_evt` pulse raises both the received-data cause and the line-status cause, each becoming active or hidden according to its own enable.
- R9: Rewriting an enable bit with its current value has no side effect. In particular, a cleared transmit interrupt is not raised again while `thr_empty` is 1.
- R10: `iir_q` bit 0 is 0 when any cause is active and 1 when none is. Bits 2:1 carry the code of the highest-priority active cause: line status 3, received data 2, transmit empty 1, modem status 0. With no active cause, `iir_q` reads 3'b001.
- R11: `irq` equals the value of `out2` sampled at the previous clock edge ANDed with the OR of all active causes. `out2` never changes `iir_q`.
- R12: When a raising event and its clearing strobe (acknowledge, `thr_wr` or `iir_rd`) occur in the same cycle, the raising event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 4 | Enable register write data |
| iir_rd | input | 1 | Identification register read strobe |
| thr_wr | input | 1 | Host write to transmit holding register |
| thr_load | input | 1 | Holding register moved to shifter (now empty) |
| thr_empty | input | 1 | Holding register empty status |
| rx_evt | input | 1 | Received data available event |
| ls_evt | input | 1 | Line status event |
| ms_evt | input | 1 | Modem status change event |
| ovr_evt | input | 1 | Receive overrun event |
| rx_ack | input | 1 | Received-data cause discharged (data read) |
| ls_ack | input | 1 | Line-status cause discharged (status read) |
| ms_ack | input | 1 | Modem-status cause discharged (status read) |
| out2 | input | 1 | Modem control general output, gates `irq` |
| ier_q | output | 4 | Current enable register |
| iir_q | output | 3 | Identification value: {code, no-interrupt flag} |
| irq | output | 1 | Interrupt request level |

## Verification
Directed sequences first separate the hidden-while-disabled path from the immediate path. They do this by raising each cause with its enable off and with it on, then toggling the enable. The same sequences show that the transmit cause differs in having no memory and in firing on an empty holding register at the moment it is enabled. Stacking several causes at once checks the priority order. Running them with `out2` at 0 shows that the pin is gated while the identification value stays unchanged.

A long stretch of sparse random strobes then reaches same-cycle collisions between writes, events and clears. A behavioural model that keeps one flag per cause checks every cycle. It tells apart designs that resolve these collisions in the wrong order.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int NSRC   = 4;
  localparam int IDW    = 2;
  localparam int IIRW   = IDW + 1;
  localparam int SRC_RX = 0;
  localparam int SRC_TX = 1;
  localparam int SRC_LS = 2;
  localparam int SRC_MS = 3;

  typedef enum logic [IDW-1:0] {
    ID_MS = 2'd0,
    ID_TX = 2'd1,
    ID_RX = 2'd2,
    ID_LS = 2'd3
  } irq_id_e;
endpackage

// File: rtl/uirq_latch.sv
module uirq_latch (
  input  logic clk,
  input  logic rst,
  input  logic en_next,
  input  logic raise,
  input  logic ack,
  output logic act_q
);
  logic pend_q;
  logic held;

  // a cause is outstanding if raised now or kept from before and not discharged
  assign held = raise | ((act_q | pend_q) & ~ack);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      act_q  <= en_next & held;
      pend_q <= ~en_next & held;
    end
  end

  AST_ACT_PEND_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(act_q && pend_q)); // R4
  AST_PEND_WAKE: assert property (@(posedge clk) disable iff (rst)
    (pend_q && en_next && !ack) |=> act_q); // R3
  AST_RAISE_WINS: assert property (@(posedge clk) disable iff (rst)
    (raise && ack && en_next) |=> act_q); // R12
endmodule

// File: rtl/uirq_txsrc.sv
module uirq_txsrc (
  input  logic clk,
  input  logic rst,
  input  logic en_now,
  input  logic en_next,
  input  logic thr_empty,
  input  logic thr_load,
  input  logic clr,
  output logic act_q
);
  logic wake;
  logic keep;

  assign wake = en_next & ~en_now & thr_empty;
  assign keep = act_q & ~clr;

  always_ff @(posedge clk) begin
    if (rst) act_q <= 1'b0;
    else     act_q <= en_next & (thr_load | wake | keep);
  end

  AST_TX_OFF: assert property (@(posedge clk) disable iff (rst)
    !en_next |=> !act_q); // R6
  AST_TX_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!act_q && !thr_load && !(en_next && !en_now)) |=> !act_q); // R9
  AST_TX_CLR: assert property (@(posedge clk) disable iff (rst)
    (clr && !thr_load && !(en_next && !en_now)) |=> !act_q); // R6
endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
  import uirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] act,
  input  logic            out2,
  output logic [IIRW-1:0] iir_q,
  output logic            irq
);
  logic           out2_q;
  logic [IDW-1:0] code;
  logic           any;

  always_ff @(posedge clk) begin
    if (rst) out2_q <= 1'b0;
    else     out2_q <= out2;
  end

  always_comb begin
    any = |act;
    if (act[SRC_LS])      code = ID_LS;
    else if (act[SRC_RX]) code = ID_RX;
    else if (act[SRC_TX]) code = ID_TX;
    else                  code = ID_MS;
    iir_q = {code, ~any};
  end

  assign irq = out2_q & any;
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            ier_wr,
  input  logic [NSRC-1:0] ier_wdata,
  input  logic            iir_rd,
  input  logic            thr_wr,
  input  logic            thr_load,
  input  logic            thr_empty,
  input  logic            rx_evt,
  input  logic            ls_evt,
  input  logic            ms_evt,
  input  logic            ovr_evt,
  input  logic            rx_ack,
  input  logic            ls_ack,
  input  logic            ms_ack,
  input  logic            out2,
  output logic [NSRC-1:0] ier_q,
  output logic [IIRW-1:0] iir_q,
  output logic            irq
);
  logic [NSRC-1:0] ier_n;
  logic [NSRC-1:0] raise;
  logic [NSRC-1:0] ack;
  logic [NSRC-1:0] act;

  assign ier_n = ier_wr ? ier_wdata : ier_q;

  always_ff @(posedge clk) begin
    if (rst) ier_q <= '0;
    else     ier_q <= ier_n;
  end

  assign raise[SRC_RX] = rx_evt | ovr_evt;
  assign raise[SRC_LS] = ls_evt | ovr_evt;
  assign raise[SRC_MS] = ms_evt;
  assign raise[SRC_TX] = thr_load;
  assign ack[SRC_RX]   = rx_ack;
  assign ack[SRC_LS]   = ls_ack;
  assign ack[SRC_MS]   = ms_ack;
  assign ack[SRC_TX]   = thr_wr | iir_rd;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    if (g == SRC_TX) begin : g_tx
      uirq_txsrc u_tx (
        .clk       (clk),
        .rst       (rst),
        .en_now    (ier_q[g]),
        .en_next   (ier_n[g]),
        .thr_empty (thr_empty),
        .thr_load  (raise[g]),
        .clr       (ack[g]),
        .act_q     (act[g])
      );
    end else begin : g_lat
      uirq_latch u_lat (
        .clk     (clk),
        .rst     (rst),
        .en_next (ier_n[g]),
        .raise   (raise[g]),
        .ack     (ack[g]),
        .act_q   (act[g])
      );
    end
  end

  uirq_prio u_prio (
    .clk   (clk),
    .rst   (rst),
    .act   (act),
    .out2  (out2),
    .iir_q (iir_q),
    .irq   (irq)
  );

  AST_ACT_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    (act & ~ier_q) == '0); // R3
  AST_IIR_IDLE: assert property (@(posedge clk) disable iff (rst)
    (act == '0) |-> (iir_q == 3'b001)); // R10
  AST_IRQ_NEEDS_ACT: assert property (@(posedge clk) disable iff (rst)
    irq |-> (act != '0)); // R11
  AST_IRQ_OUT2: assert property (@(posedge clk) disable iff (rst)
    !$past(out2) |-> !irq); // R11
endmodule

// File: tb/uart_irq_ctrl_test.sv
module uart_irq_ctrl_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst;
  logic ier_wr, iir_rd, thr_wr, thr_load, thr_empty;
  logic rx_evt, ls_evt, ms_evt, ovr_evt, rx_ack, ls_ack, ms_ack, out2;
  logic [3:0] ier_wdata;
  logic [3:0] ier_q;
  logic [2:0] iir_q;
  logic irq;

  uart_irq_ctrl uut (
    .clk(clk), .rst(rst), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
    .iir_rd(iir_rd), .thr_wr(thr_wr), .thr_load(thr_load),
    .thr_empty(thr_empty), .rx_evt(rx_evt), .ls_evt(ls_evt),
    .ms_evt(ms_evt), .ovr_evt(ovr_evt), .rx_ack(rx_ack),
    .ls_ack(ls_ack), .ms_ack(ms_ack), .out2(out2),
    .ier_q(ier_q), .iir_q(iir_q), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit checking = 0;

  // behavioural model: one outstanding flag per cause, masked by enable
  logic [3:0] m_ier;
  logic m_rx, m_ls, m_ms, m_tx, m_out2;

  always @(posedge clk) begin
    logic [3:0] nier;
    if (rst) begin
      m_ier = 0; m_rx = 0; m_ls = 0; m_ms = 0; m_tx = 0; m_out2 = 0;
    end else begin
      nier = ier_wr ? ier_wdata : m_ier;
      if (rx_evt || ovr_evt) m_rx = 1; else if (rx_ack) m_rx = 0;
      if (ls_evt || ovr_evt) m_ls = 1; else if (ls_ack) m_ls = 0;
      if (ms_evt) m_ms = 1; else if (ms_ack) m_ms = 0;
      if (!nier[1]) m_tx = 0;
      else if (thr_load || (!m_ier[1] && thr_empty)) m_tx = 1;
      else if (thr_wr || iir_rd) m_tx = 0;
      m_ier = nier;
      m_out2 = out2;
    end
  end

  function automatic logic [2:0] exp_iir();
    if (m_ls && m_ier[2]) return 3'b110;
    if (m_rx && m_ier[0]) return 3'b100;
    if (m_tx) return 3'b010;
    if (m_ms && m_ier[3]) return 3'b000;
    return 3'b001;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      chk("R2", "ier_q", int'(ier_q), int'(m_ier));
      chk(cur_req, "iir_q", int'(iir_q), int'(exp_iir()));
      chk("R11", "irq", int'(irq), int'(m_out2 && (exp_iir() != 3'b001)));
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    ier_wr = 0; iir_rd = 0; thr_wr = 0; thr_load = 0;
    rx_evt = 0; ls_evt = 0; ms_evt = 0; ovr_evt = 0;
    rx_ack = 0; ls_ack = 0; ms_ack = 0;
  endtask

  task automatic wr(logic [3:0] v);
    ier_wr = 1; ier_wdata = v; tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired (all requirements)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; ier_wdata = 0; thr_empty = 0; out2 = 1;
    ier_wr = 0; iir_rd = 0; thr_wr = 0; thr_load = 0;
    rx_evt = 0; ls_evt = 0; ms_evt = 0; ovr_evt = 0;
    rx_ack = 0; ls_ack = 0; ms_ack = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    tick();
    chk("R1", "reset ier_q", int'(ier_q), 0);
    chk("R1", "reset iir_q", int'(iir_q), 1);
    chk("R1", "reset irq", int'(irq), 0);
    checking = 1;

    cur_req = "R3";
    rx_evt = 1; tick();
    chk("R3", "hidden rx", int'(iir_q), 1);
    wr(4'b0001);
    chk("R3", "rx woken", int'(iir_q), 3'b100);
    ms_evt = 1; wr(4'b1001); tick();

    cur_req = "R4";
    wr(4'b0000);
    chk("R4", "rx hidden again", int'(iir_q), 1);
    wr(4'b0001);
    rx_ack = 1; tick();
    ms_ack = 1; tick();
    chk("R4", "all discharged", int'(iir_q), 1);

    cur_req = "R5";
    thr_empty = 1; wr(4'b0010);
    chk("R5", "tx on enable", int'(iir_q), 3'b010);
    cur_req = "R6";
    thr_wr = 1; tick();
    chk("R6", "tx cleared by thr_wr", int'(iir_q), 1);
    cur_req = "R9";
    wr(4'b0010); tick();
    chk("R9", "no refire on rewrite", int'(iir_q), 1);
    cur_req = "R5";
    wr(4'b0000); thr_empty = 0; wr(4'b0010);
    chk("R5", "no tx when full", int'(iir_q), 1);

    cur_req = "R7";
    thr_load = 1; tick();
    chk("R7", "tx on load", int'(iir_q), 3'b010);
    cur_req = "R6";
    iir_rd = 1; tick();
    wr(4'b0000);
    cur_req = "R7";
    thr_load = 1; tick();
    wr(4'b0010);
    chk("R7", "no tx memory", int'(iir_q), 1);
    cur_req = "R6";
    thr_load = 1; tick(); wr(4'b0000);
    chk("R6", "tx cleared by disable", int'(iir_q), 1);

    cur_req = "R8";
    ovr_evt = 1; tick();
    wr(4'b1111);
    chk("R8", "ls first", int'(iir_q), 3'b110);
    ls_ack = 1; tick();
    chk("R8", "rx next", int'(iir_q), 3'b100);

    cur_req = "R10";
    ms_evt = 1; thr_load = 1; tick();
    rx_ack = 1; tick();
    chk("R10", "tx above ms", int'(iir_q), 3'b010);
    iir_rd = 1; tick();
    chk("R10", "ms last", int'(iir_q), 3'b000);

    cur_req = "R11";
    out2 = 0; tick(); tick();
    chk("R11", "gated irq", int'(irq), 0);
    chk("R11", "iir unaffected", int'(iir_q), 3'b000);
    out2 = 1; ms_ack = 1; tick();

    cur_req = "R12";
    rx_evt = 1; rx_ack = 1; tick();
    chk("R12", "event beats ack", int'(iir_q), 3'b100);
    thr_load = 1; thr_wr = 1; rx_ack = 1; tick();
    chk("R12", "load beats thr_wr", int'(iir_q), 3'b010);

    cur_req = "R10";
    for (int i = 0; i < 3000; i++) begin
      ier_wr = ($urandom % 6) == 0; ier_wdata = 4'($urandom);
      iir_rd = ($urandom % 7) == 0; thr_wr = ($urandom % 7) == 0;
      thr_load = ($urandom % 7) == 0; thr_empty = 1'($urandom);
      rx_evt = ($urandom % 8) == 0; ls_evt = ($urandom % 8) == 0;
      ms_evt = ($urandom % 8) == 0; ovr_evt = ($urandom % 12) == 0;
      rx_ack = ($urandom % 6) == 0; ls_ack = ($urandom % 6) == 0;
      ms_ack = ($urandom % 6) == 0; out2 = ($urandom % 4) != 0;
      tick();
    end

    checking = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule